// File: doc/BRIEF.md
# ARINC 429 Transmit Serializer

This block turns 31-bit payload words, offered by an upstream word buffer, into 32-bit serial words on a complementary pair of return-to-zero line outputs. When transmission is enabled and a word is available, the block takes the word, adds a parity bit chosen for odd or even overall parity, and sends the 32 bits one at a time. Each bit has a data phase, in which one of the two outputs is high, and then a null phase, in which both are low. A fixed gap follows every word.

The clock counts for data, null and gap come from parameters, with one set for the fast rate and one for the slow rate. A self-test switch copies the two line outputs onto a pair of loopback outputs that feed a local receiver. The line outputs keep running while the switch is on. If enable is removed in the middle of a word, that word is dropped. A synchronous reset stops all activity immediately.

Top module: `a429_tx_serializer`

## Requirements
- R1: Bit 32 of each frame is parity over the 31 payload bits. With `even_par`=0 the frame carries an odd number of ones, and with `even_par`=1 an even number. `even_par` is sampled in the cycle the word is taken.
- R2: Bits go out starting with bit 1 (`word_data[0]`) and ending with bit 31 (`word_data[30]`), followed by the parity bit.
- R3: During a data phase, a 1 drives `line_hi`=1 and `line_lo`=0, and a 0 drives the reverse. During null phases, the word gap and idle, both outputs are 0.
- R4: With `slow_rate`=0, each bit has 5 data clocks and 5 null clocks, and the word gap lasts 40 clocks.
- R5: With `slow_rate`=1, each bit has 40 data clocks and 40 null clocks, and the gap lasts 320 clocks. The rate is sampled when the word is taken and held for the whole frame.
- R6: When idle, with `tx_en`=1 and `word_avail`=1, `word_take` is 1 in that same cycle, and the first data bit shows on the outputs in the next cycle.
- R7: When a word is waiting, it is taken in the last gap clock, so the gap lasts exactly the programmed number of clocks before the next frame starts.
- R8: If `tx_en` is 0 while a frame or gap is in progress, both line outputs are 0 from the next cycle on and the block goes idle. The interrupted word is never sent again.
- R9: `rst`=1 sends the block idle at the next clock edge with both line outputs 0, and suppresses `word_take` during the reset cycle.
- R10: With `self_test`=1, `loop_rx1` follows `line_hi` and `loop_rx2` follows `line_lo`, and the line outputs stay active. With `self_test`=0, both loopback outputs are 0.
- R11: `tx_ready` is 1 exactly when the block is idle and `word_avail`=0.
- R12: `word_take` is 1 only when `tx_en`=1, `word_avail`=1 and the block is idle or in its last gap clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| slow_rate | input | 1 | 1 selects the slow bit rate |
| even_par | input | 1 | 1 selects even parity, 0 selects odd parity |
| self_test | input | 1 | 1 routes the line outputs to the loopback outputs |
| word_avail | input | 1 | The upstream buffer holds a word |
| word_data | input | 31 | Payload of the word at the head of the buffer |
| word_take | output | 1 | Pops the head word at this clock edge |
| line_hi | output | 1 | True line output |
| line_lo | output | 1 | Complemented line output |
| loop_rx1 | output | 1 | Loopback copy of the true output |
| loop_rx2 | output | 1 | Loopback copy of the complemented output |
| tx_ready | output | 1 | Idle with no word waiting |

## Verification
The hardest cases to reach from the ports are a change of state that lands exactly on a phase boundary: a word taken in the very last gap clock, an enable removed partway through a frame, and a reset in the middle of a bit. The bench models the upstream buffer and holds a queue of the expected line values for every clock. It changes rate, parity and self-test while frames are running, and it removes enable and asserts reset at random offsets as well as at fixed points. This way the latching of the rate and the dropping of an interrupted word are checked one clock at a time.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    localparam int PAYLOAD_W = 31;
    localparam int FRAME_W   = PAYLOAD_W + 1;
    localparam int IDX_W     = $clog2(FRAME_W);

    localparam int DEF_FAST_DATA = 5;
    localparam int DEF_FAST_NULL = 5;
    localparam int DEF_FAST_GAP  = 40;
    localparam int DEF_SLOW_DATA = 40;
    localparam int DEF_SLOW_NULL = 40;
    localparam int DEF_SLOW_GAP  = 320;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_NULL = 2'd2,
        PH_GAP  = 2'd3
    } phase_e;

    typedef struct packed {
        logic                 par;
        logic [PAYLOAD_W-1:0] payload;
    } frame_s;

    // Parity bit that gives the whole frame odd (even=0) or even (even=1) ones.
    function automatic logic frame_parity(input logic [PAYLOAD_W-1:0] w, input logic even);
        return even ? (^w) : ~(^w);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/a429_phase_timer.sv
module a429_phase_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] len,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == len - 1'b1);

    // R4/R5: a phase never runs past its programmed length
    p_phase_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (len != '0) |-> (cnt_q < len));

endmodule

// File: rtl/a429_frame_shifter.sv
module a429_frame_shifter
    import a429_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 shift,
    input  logic [PAYLOAD_W-1:0] payload,
    input  logic                 even,
    output logic                 cur_bit,
    output logic                 last
);

    frame_s           sr_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sr_q.par     <= frame_parity(payload, even);
            sr_q.payload <= payload;
            idx_q        <= '0;
        end else if (shift) begin
            sr_q  <= frame_s'({1'b0, sr_q[FRAME_W-1:1]});
            idx_q <= idx_q + 1'b1;
        end
    end

    assign cur_bit = sr_q.payload[0];
    assign last    = (idx_q == IDX_W'(FRAME_W - 1));

    // R1: the frame just loaded holds odd ones for odd mode, even ones for even mode
    p_frame_parity_r1: assert property (@(posedge clk) disable iff (rst)
        load |=> ((^sr_q) != $past(even)));

    // R2: a load restarts at bit 1
    p_load_restart_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (idx_q == '0) && (cur_bit == $past(payload[0])));

endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer
    import a429_tx_pkg::*;
#(
    parameter int FAST_DATA = DEF_FAST_DATA,
    parameter int FAST_NULL = DEF_FAST_NULL,
    parameter int FAST_GAP  = DEF_FAST_GAP,
    parameter int SLOW_DATA = DEF_SLOW_DATA,
    parameter int SLOW_NULL = DEF_SLOW_NULL,
    parameter int SLOW_GAP  = DEF_SLOW_GAP
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tx_en,
    input  logic                 slow_rate,
    input  logic                 even_par,
    input  logic                 self_test,
    input  logic                 word_avail,
    input  logic [PAYLOAD_W-1:0] word_data,
    output logic                 word_take,
    output logic                 line_hi,
    output logic                 line_lo,
    output logic                 loop_rx1,
    output logic                 loop_rx2,
    output logic                 tx_ready
);

    localparam int PH_MAX = max3(max3(FAST_DATA, FAST_NULL, FAST_GAP),
                                 max3(SLOW_DATA, SLOW_NULL, SLOW_GAP), 1);
    localparam int CNT_W  = $clog2(PH_MAX + 1);

    phase_e           phase_q, phase_d;
    logic             slow_q;
    logic [CNT_W-1:0] cur_len;
    logic             tm_done, tm_clr;
    logic             sh_bit, sh_last, sh_shift;
    logic             can_start;

    // Length of the phase in progress, chosen by the rate latched for this frame
    always_comb begin
        unique case (phase_q)
            PH_DATA: cur_len = slow_q ? CNT_W'(SLOW_DATA) : CNT_W'(FAST_DATA);
            PH_NULL: cur_len = slow_q ? CNT_W'(SLOW_NULL) : CNT_W'(FAST_NULL);
            PH_GAP:  cur_len = slow_q ? CNT_W'(SLOW_GAP)  : CNT_W'(FAST_GAP);
            default: cur_len = CNT_W'(1);
        endcase
    end

    assign can_start = (phase_q == PH_IDLE) || ((phase_q == PH_GAP) && tm_done);
    assign word_take = !rst && tx_en && word_avail && can_start;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (word_take) phase_d = PH_DATA;
            PH_DATA: if (tm_done)   phase_d = PH_NULL;
            PH_NULL: if (tm_done)   phase_d = sh_last ? PH_GAP : PH_DATA;
            PH_GAP:  if (tm_done)   phase_d = word_take ? PH_DATA : PH_IDLE;
            default:                phase_d = PH_IDLE;
        endcase
        if (!tx_en) phase_d = PH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            slow_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (word_take) slow_q <= slow_rate;
        end
    end

    assign tm_clr   = (phase_q == PH_IDLE) || tm_done || !tx_en;
    assign sh_shift = (phase_q == PH_NULL) && tm_done && !sh_last;

    a429_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (tm_clr),
        .len  (cur_len),
        .done (tm_done)
    );

    a429_frame_shifter u_shifter (
        .clk     (clk),
        .rst     (rst),
        .load    (word_take),
        .shift   (sh_shift),
        .payload (word_data),
        .even    (even_par),
        .cur_bit (sh_bit),
        .last    (sh_last)
    );

    assign line_hi  = (phase_q == PH_DATA) &&  sh_bit;
    assign line_lo  = (phase_q == PH_DATA) && !sh_bit;
    assign loop_rx1 = self_test && line_hi;
    assign loop_rx2 = self_test && line_lo;
    assign tx_ready = (phase_q == PH_IDLE) && !word_avail;

    // R3: exactly one line high in a data phase, whatever the self-test setting
    p_data_one_hot_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA) |-> (line_hi ^ line_lo));

    // R6: a word taken from idle shows its first bit on the next cycle
    p_start_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (word_take && phase_q == PH_IDLE && !rst) |=> (line_hi || line_lo));

    // R7: a word taken at the gap end goes straight to a data phase
    p_gap_handoff_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_GAP && word_take) |=> (phase_q == PH_DATA));

    // R8: dropping enable quiets the line on the next cycle
    p_abort_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && phase_q != PH_IDLE) |=> (phase_q == PH_IDLE && !line_hi && !line_lo));

    // R9: reset lands in idle with a quiet line
    p_reset_idle_r9: assert property (@(posedge clk)
        rst |=> (phase_q == PH_IDLE && !line_hi && !line_lo));

    // R5: the rate is held for the whole frame
    p_rate_held_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && !word_take) |=> $stable(slow_q));

    // R12: a take only happens with enable and a word on offer
    p_take_gated_r12: assert property (@(posedge clk) disable iff (rst)
        word_take |-> (tx_en && word_avail));

endmodule

// File: tb/test_a429_tx_serializer.sv
module test_a429_tx_serializer;

    localparam int CLK_PERIOD = 10;
    localparam int F_DATA = 5,  F_NULL = 5,  F_GAP = 40;
    localparam int S_DATA = 40, S_NULL = 40, S_GAP = 320;

    logic        clk = 1'b0;
    logic        rst, tx_en, slow_rate, even_par, self_test;
    logic        word_avail;
    logic [30:0] word_data;
    logic        word_take, line_hi, line_lo, loop_rx1, loop_rx2, tx_ready;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // Upstream buffer model
    logic [30:0] buf_mem [0:255];
    int wr_ptr = 0;
    int rd_ptr = 0;
    assign word_avail = (wr_ptr != rd_ptr);
    assign word_data  = buf_mem[rd_ptr[7:0]];

    // Expected per-clock line values
    bit    exp_hi[$];
    bit    exp_lo[$];
    string exp_tag[$];
    string idle_tag = "R3";

    always #(CLK_PERIOD/2) clk = ~clk;

    a429_tx_serializer i_a429_tx_serializer (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .slow_rate  (slow_rate),
        .even_par   (even_par),
        .self_test  (self_test),
        .word_avail (word_avail),
        .word_data  (word_data),
        .word_take  (word_take),
        .line_hi    (line_hi),
        .line_lo    (line_lo),
        .loop_rx1   (loop_rx1),
        .loop_rx2   (loop_rx2),
        .tx_ready   (tx_ready)
    );

    always @(posedge clk) if (word_take) rd_ptr <= rd_ptr + 1;

    task automatic check(input logic got, input logic exp, input string req, input string what);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    function automatic bit exp_parity(input logic [30:0] w, input bit even);
        return even ? ^w : !(^w);
    endfunction

    task automatic push_frame(input logic [30:0] w, input bit slow, input bit even, input bit from_idle);
        int d = slow ? S_DATA : F_DATA;
        int n = slow ? S_NULL : F_NULL;
        int g = slow ? S_GAP  : F_GAP;
        string spd = slow ? "R5" : "R4";
        bit par = exp_parity(w, even);
        for (int b = 0; b < 32; b++) begin
            bit v = (b == 31) ? par : w[b];
            for (int c = 0; c < d; c++) begin
                exp_hi.push_back(v);
                exp_lo.push_back(!v);
                exp_tag.push_back((b == 0 && c == 0 && from_idle) ? "R6" : (b == 31) ? "R1" : "R2");
            end
            for (int c = 0; c < n; c++) begin
                exp_hi.push_back(1'b0); exp_lo.push_back(1'b0); exp_tag.push_back(spd);
            end
        end
        for (int c = 0; c < g; c++) begin
            exp_hi.push_back(1'b0); exp_lo.push_back(1'b0);
            exp_tag.push_back((c == g - 1) ? "R7" : spd);
        end
    endtask

    // Monitor, away from the active edge
    always @(negedge clk) begin
        bit idle_now;
        bit ehi, elo, etake;
        string et;
        if (!rst || exp_hi.size() != 0 || idle_tag != "R3") begin
            idle_now = (exp_hi.size() == 0);
            ehi = 1'b0; elo = 1'b0; et = idle_tag;
            if (!idle_now) begin
                ehi = exp_hi.pop_front(); elo = exp_lo.pop_front(); et = exp_tag.pop_front();
            end else begin
                idle_tag = "R3";
            end
            check(line_hi, ehi, et, "line_hi");
            check(line_lo, elo, et, "line_lo");
            check(loop_rx1, self_test & ehi, "R10", "loop_rx1");
            check(loop_rx2, self_test & elo, "R10", "loop_rx2");
            check(tx_ready, idle_now && (wr_ptr == rd_ptr), "R11", "tx_ready");
            etake = tx_en && (wr_ptr != rd_ptr) && !rst && (exp_hi.size() == 0);
            check(word_take, etake, (etake && !idle_now) ? "R7" : "R12", "word_take");
            if (word_take) push_frame(word_data, slow_rate, even_par, idle_now);
            if (rst) begin
                exp_hi.delete(); exp_lo.delete(); exp_tag.delete(); idle_tag = "R9";
            end else if (!tx_en && exp_hi.size() != 0) begin
                exp_hi.delete(); exp_lo.delete(); exp_tag.delete(); idle_tag = "R8";
            end
        end
    end

    task automatic put_word(input logic [30:0] w);
        buf_mem[wr_ptr[7:0]] = w;
        wr_ptr++;
    endtask

    task automatic cycles(input int n, input bit jitter);
        repeat (n) begin
            @(posedge clk); #2;
            if (jitter) begin
                self_test = 1'($urandom % 2);
                if ($urandom % 16 == 0) slow_rate = 1'($urandom % 2);
                if ($urandom % 8 == 0)  even_par  = 1'($urandom % 2);
            end
        end
    endtask

    task automatic wait_ready(input bit jitter);
        for (int i = 0; i < 20000; i++) begin
            cycles(1, jitter);
            if (tx_ready && exp_hi.size() == 0) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: got hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; tx_en = 1'b0; slow_rate = 1'b0; even_par = 1'b0; self_test = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R9: quiet, ready state after reset
        check(line_hi, 1'b0, "R9", "line_hi after reset");
        check(line_lo, 1'b0, "R9", "line_lo after reset");
        check(tx_ready, 1'b1, "R9", "tx_ready after reset");
        @(posedge clk); #2;

        // R1: all zeros, odd parity gives a 1 in bit 32
        put_word(31'h0);
        tx_en = 1'b1;
        wait_ready(1'b0);
        // R1/R7: all ones with even parity, followed back to back by a second word
        even_par = 1'b1; self_test = 1'b1;
        put_word(31'h7FFF_FFFF);
        put_word(31'h1234_5678);
        wait_ready(1'b0);
        // R5: slow rate, the rate input changes while the frame runs
        even_par = 1'b0; slow_rate = 1'b1;
        put_word(31'h2AAA_AAAA);
        cycles(3, 1'b0);
        slow_rate = 1'b0;
        wait_ready(1'b0);
        // R8: enable removed partway through a frame
        put_word(31'h0F0F_0F0F);
        put_word(31'h5555_0001);
        cycles(50, 1'b0);
        tx_en = 1'b0;
        cycles(6, 1'b0);
        tx_en = 1'b1;
        wait_ready(1'b0);
        // R9: reset in the middle of a bit
        put_word(31'h7000_0003);
        put_word(31'h0000_0ABC);
        cycles(97, 1'b0);
        rst = 1'b1;
        cycles(1, 1'b0);
        rst = 1'b0;
        wait_ready(1'b0);

        // Random episodes
        for (int ep = 0; ep < 14; ep++) begin
            int nw = 1 + int'($urandom % 3);
            slow_rate = ($urandom % 4 == 0);
            for (int k = 0; k < nw; k++) put_word(31'($urandom));
            tx_en = 1'b1;
            if ($urandom % 3 == 0) begin
                cycles(1 + int'($urandom % 400), 1'b1);
                tx_en = 1'b0;
                cycles(1 + int'($urandom % 5), 1'b1);
                tx_en = 1'b1;
            end
            wait_ready(1'b1);
            tx_en = ($urandom % 2 == 0);
            cycles(1 + int'($urandom % 4), 1'b1);
        end

        tx_en = 1'b0;
        cycles(4, 1'b0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule